// File: doc/BRIEF.md
# Clock, Reset and Power-Mode Controller

This block turns the oscillator input of a small 8-bit microcontroller into the timing that the core and its peripherals run on. A toggle flop halves the oscillator rate. A state counter groups those half-rate ticks into machine cycles of six states, which is twelve oscillator periods. The block produces a clock enable for the CPU, a clock enable for the peripherals (RAM, timers, serial port, interrupt logic), a one-period strobe at the start of every machine cycle, and a synchronous core reset.

The raw reset pin is not trusted as it arrives. It becomes a core reset only after it has been sampled high at two consecutive machine-cycle boundaries, with no low sample at any edge in between. The core reset is released at a machine-cycle boundary. A two-bit mode register, written by the CPU at one register address, selects idle, which stops only the CPU enable, or power-down, which freezes the whole divider. An interrupt request ends idle at the next boundary. Power-down ends only through a qualified reset.

All state sits in plain edge-triggered flops with no dynamic element, so the block holds its state when the oscillator slows or stops.

Top module: `mcu_clkpwr`

## Requirements
- R1: Outside power-down, `mcyc_stb` is high for exactly one oscillator period out of every 12, and that period opens a machine cycle (a boundary).
- R2: Outside power-down, `per_ce` is high on every second oscillator period, which gives 6 pulses per machine cycle. `cpu_ce` follows the same pattern unless idle or power-down is active.
- R3: `core_rst` rises at a boundary edge only when `rst_pin` was sampled high at that boundary and at the one before it, with no low sample at any edge in between. A shorter pulse, or one broken by a single low sample, has no effect.
- R4: `core_rst` is high from power-up. It falls at the first boundary edge at which `rst_pin` is sampled low.
- R5: A qualified reset clears both mode bits, and both stay clear while `core_rst` is high.
- R6: A write with `sfr_we` high and `sfr_addr` equal to 0x87 loads the mode register: `pcon_wdata` bit 0 requests idle and bit 1 requests power-down. When both bits are set, only power-down is entered. Writes to any other address are ignored. Writes are also ignored while idle, power-down or `core_rst` is active.
- R7: In idle, `cpu_ce` stays low while `per_ce` and `mcyc_stb` keep running.
- R8: In idle, `wake_irq` sampled high at a boundary edge clears idle at that edge. `wake_irq` has no effect on power-down.
- R9: In power-down, `per_ce`, `cpu_ce` and `mcyc_stb` stay low. Only a qualified reset leaves power-down, and a short reset pulse leaves the block in power-down.
- R10: When the oscillator is stopped and then restarted, the machine-cycle timing resumes from where it stopped: the strobe spacing stays at 12 counted periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator input; all state changes on its rising edge |
| rst_pin | input | 1 | Raw active-high reset pin, not yet qualified |
| sfr_we | input | 1 | Register write strobe from the CPU |
| sfr_addr | input | 8 | Register address of the write |
| pcon_wdata | input | 2 | Mode bits of the write data: bit 0 idle, bit 1 power-down |
| wake_irq | input | 1 | Any enabled interrupt request |
| cpu_ce | output | 1 | CPU clock enable |
| per_ce | output | 1 | Peripheral clock enable |
| core_rst | output | 1 | Synchronous core reset |
| mcyc_stb | output | 1 | Machine-cycle strobe |
| idle_mode | output | 1 | Idle mode is active |
| pdown_mode | output | 1 | Power-down mode is active |

## Verification
The bench aligns reset pulses to the strobe, so it can tell a pulse that covers one boundary from one that covers two. A qualifier that counted edges instead of boundaries, or that did not restart after a one-period dip, would raise the core reset in those runs. The exit from idle is timed to the exact boundary edge; a design that woke at once on the request, or one boundary late, fails that check. In power-down the bench sends a one-period reset pulse, an interrupt and a mode write, and a design that left power-down on any of them, or that let a simultaneous idle request through, shows it on the mode and enable outputs. A pause of the oscillator in the middle of a machine cycle catches a divider that restarts its count after a stall.

// File: rtl/mcu_clkpwr.sv
module mcu_clkpwr #(
  parameter int STATES = 6,
  parameter int QUAL_CYCLES = 2,
  parameter logic [7:0] PCON_ADDR = 8'h87
) (
  input  logic       osc_clk,
  input  logic       rst_pin,
  input  logic       sfr_we,
  input  logic [7:0] sfr_addr,
  input  logic [1:0] pcon_wdata,
  input  logic       wake_irq,
  output logic       cpu_ce,
  output logic       per_ce,
  output logic       core_rst,
  output logic       mcyc_stb,
  output logic       idle_mode,
  output logic       pdown_mode
);
  localparam int SW = (STATES > 1) ? $clog2(STATES) : 1;
  localparam int QW = $clog2(QUAL_CYCLES + 1);
  localparam logic [SW-1:0] LAST_ST = SW'(STATES - 1);
  localparam logic [QW-1:0] QUAL_MAX = QW'(QUAL_CYCLES);
  localparam logic [QW-1:0] QUAL_LAST = QW'(QUAL_CYCLES - 1);

  logic          ph_q = 1'b0;
  logic [SW-1:0] st_q = '0;
  logic [QW-1:0] qual_q = '0;
  logic          rst_q = 1'b1;
  logic          idle_q = 1'b0;
  logic          pd_q = 1'b0;

  logic run, bnd, pcon_hit, qual_hit;

  assign run      = !pd_q || rst_pin;
  assign bnd      = run && !ph_q && (st_q == '0);
  assign pcon_hit = sfr_we && (sfr_addr == PCON_ADDR) && !idle_q && !pd_q && !rst_q;
  assign qual_hit = bnd && rst_pin && (qual_q >= QUAL_LAST);

  always_ff @(posedge osc_clk) begin
    if (run) begin
      ph_q <= !ph_q;
      if (ph_q) st_q <= (st_q == LAST_ST) ? '0 : st_q + SW'(1);
    end
  end

  always_ff @(posedge osc_clk) begin
    if (!rst_pin) qual_q <= '0;
    else if (bnd && qual_q != QUAL_MAX) qual_q <= qual_q + QW'(1);
  end

  always_ff @(posedge osc_clk) begin
    if (qual_hit) rst_q <= 1'b1;
    else if (bnd && !rst_pin) rst_q <= 1'b0;
  end

  always_ff @(posedge osc_clk) begin
    if (qual_hit) begin
      idle_q <= 1'b0;
      pd_q   <= 1'b0;
    end else if (pcon_hit) begin
      pd_q   <= pcon_wdata[1];
      idle_q <= pcon_wdata[0] && !pcon_wdata[1];
    end else if (idle_q && bnd && wake_irq) begin
      idle_q <= 1'b0;
    end
  end

  assign per_ce     = ph_q && !pd_q;
  assign cpu_ce     = per_ce && !idle_q;
  assign mcyc_stb   = bnd;
  assign core_rst   = rst_q;
  assign idle_mode  = idle_q;
  assign pdown_mode = pd_q;
endmodule

// File: rtl/mcu_clkpwr_sva.sv
module mcu_clkpwr_sva (
  input logic       osc_clk,
  input logic       rst_pin,
  input logic       wake_irq,
  input logic       cpu_ce,
  input logic       per_ce,
  input logic       core_rst,
  input logic       mcyc_stb,
  input logic       idle_mode,
  input logic       pdown_mode
);
  logic armed = 1'b0;
  always_ff @(posedge osc_clk) armed <= 1'b1;

  assert_stb_single_R1: assert property (@(posedge osc_clk) disable iff (!armed)
    mcyc_stb |=> !mcyc_stb);
  assert_ce_alternate_R2: assert property (@(posedge osc_clk) disable iff (!armed)
    per_ce |=> !per_ce);
  assert_rst_rise_R3: assert property (@(posedge osc_clk) disable iff (!armed)
    $rose(core_rst) |-> $past(rst_pin) && $past(mcyc_stb));
  assert_rst_fall_R4: assert property (@(posedge osc_clk) disable iff (!armed)
    $fell(core_rst) |-> !$past(rst_pin) && $past(mcyc_stb));
  assert_rst_modes_clear_R5: assert property (@(posedge osc_clk) disable iff (!armed)
    core_rst |-> !idle_mode && !pdown_mode);
  assert_pd_priority_R6: assert property (@(posedge osc_clk) disable iff (!armed)
    $rose(pdown_mode) |-> !idle_mode);
  assert_idle_cpu_off_R7: assert property (@(posedge osc_clk) disable iff (!armed)
    idle_mode |-> !cpu_ce);
  assert_wake_boundary_R8: assert property (@(posedge osc_clk) disable iff (!armed)
    $fell(idle_mode) |-> $past(mcyc_stb) && ($past(wake_irq) || core_rst));
  assert_pd_gates_R9: assert property (@(posedge osc_clk) disable iff (!armed)
    pdown_mode |-> !per_ce && !cpu_ce && (!mcyc_stb || rst_pin));
  assert_pd_exit_R9: assert property (@(posedge osc_clk) disable iff (!armed)
    $fell(pdown_mode) |-> core_rst);
endmodule

bind mcu_clkpwr mcu_clkpwr_sva u_sva (
  .osc_clk(osc_clk),
  .rst_pin(rst_pin),
  .wake_irq(wake_irq),
  .cpu_ce(cpu_ce),
  .per_ce(per_ce),
  .core_rst(core_rst),
  .mcyc_stb(mcyc_stb),
  .idle_mode(idle_mode),
  .pdown_mode(pdown_mode)
);

// File: tb/mcu_clkpwr_test.sv
module mcu_clkpwr_test;
  logic       clk = 1'b0;
  logic       clk_run = 1'b1;
  logic       rst_pin = 1'b1;
  logic       sfr_we = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic [1:0] pcon_wdata = 2'b00;
  logic       wake_irq = 1'b0;
  logic       cpu_ce, per_ce, core_rst, mcyc_stb, idle_mode, pdown_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // row: {wake, addr[7:0], data[1:0], exp_idle, exp_pd}
  localparam logic [12:0] VEC [7] = '{
    {1'b0, 8'h86, 2'b11, 1'b0, 1'b0},
    {1'b0, 8'h87, 2'b00, 1'b0, 1'b0},
    {1'b0, 8'h87, 2'b01, 1'b1, 1'b0},
    {1'b1, 8'h00, 2'b00, 1'b0, 1'b0},
    {1'b0, 8'h87, 2'b10, 1'b0, 1'b1},
    {1'b0, 8'h87, 2'b00, 1'b0, 1'b1},
    {1'b1, 8'h00, 2'b00, 1'b0, 1'b1}
  };

  mcu_clkpwr uut (
    .osc_clk(clk), .rst_pin(rst_pin), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .pcon_wdata(pcon_wdata), .wake_irq(wake_irq), .cpu_ce(cpu_ce), .per_ce(per_ce),
    .core_rst(core_rst), .mcyc_stb(mcyc_stb), .idle_mode(idle_mode), .pdown_mode(pdown_mode)
  );

  initial forever begin
    #10;
    if (clk_run) clk = ~clk;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_stb();
    int n = 0;
    @(negedge clk);
    while (!mcyc_stb && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk("R1 strobe found", mcyc_stb, 1);
  endtask

  task automatic window(output int n_stb, output int n_per, output int n_cpu);
    n_stb = 0; n_per = 0; n_cpu = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      n_stb += int'(mcyc_stb);
      n_per += int'(per_ce);
      n_cpu += int'(cpu_ce);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] d);
    sfr_we = 1'b1; sfr_addr = a; pcon_wdata = d;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic full_reset();
    rst_pin = 1'b1;
    repeat (40) @(negedge clk);
    chk("R9 qualified reset asserted", core_rst, 1);
    chk("R5 pd cleared by reset", pdown_mode, 0);
    chk("R5 idle cleared by reset", idle_mode, 0);
    rst_pin = 1'b0;
    wait_stb();
    chk("R4 reset held until boundary", core_rst, 1);
    @(negedge clk);
    chk("R4 reset released at boundary", core_rst, 0);
  endtask

  initial begin
    int ns, np, nc, n;
    @(negedge clk);
    chk("R4 power-up reset", core_rst, 1);
    chk("R5 power-up idle", idle_mode, 0);
    chk("R5 power-up pd", pdown_mode, 0);
    repeat (30) @(negedge clk);
    chk("R4 reset held while pin high", core_rst, 1);
    rst_pin = 1'b0;
    wait_stb();
    chk("R4 still in reset before boundary", core_rst, 1);
    @(negedge clk);
    chk("R4 release at boundary", core_rst, 0);

    // R1 spacing and R2 enable rate
    wait_stb();
    n = 0;
    do begin @(negedge clk); n++; end while (!mcyc_stb && n < 40);
    chk("R1 strobe spacing", n, 12);
    window(ns, np, nc);
    chk("R1 strobes per window", ns, 1);
    chk("R2 per_ce per cycle", np, 6);
    chk("R2 cpu_ce per cycle", nc, 6);

    // R3 pulse covering one boundary is ignored
    wait_stb(); @(negedge clk);
    rst_pin = 1'b1;
    repeat (12) @(negedge clk);
    chk("R3 one boundary no reset", core_rst, 0);
    rst_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 short pulse ignored", core_rst, 0);

    // R3 pulse covering two boundaries, exact edge
    wait_stb(); @(negedge clk);
    rst_pin = 1'b1;
    repeat (23) @(negedge clk);
    chk("R3 not before second boundary", core_rst, 0);
    @(negedge clk);
    chk("R3 reset at second boundary", core_rst, 1);
    rst_pin = 1'b0;
    wait_stb(); @(negedge clk);
    chk("R4 release after qualified reset", core_rst, 0);

    // R3 pulse broken by one low sample
    wait_stb(); @(negedge clk);
    rst_pin = 1'b1;
    repeat (12) @(negedge clk);
    rst_pin = 1'b0;
    @(negedge clk);
    rst_pin = 1'b1;
    repeat (11) @(negedge clk);
    chk("R3 interrupted pulse ignored", core_rst, 0);
    rst_pin = 1'b0;
    repeat (2) @(negedge clk);

    // vector table: R6 R7 R8 R9
    foreach (VEC[i]) begin
      if (VEC[i][12]) begin
        wake_irq = 1'b1;
        repeat (14) @(negedge clk);
        wake_irq = 1'b0;
      end else begin
        wr(VEC[i][11:4], VEC[i][3:2]);
      end
      chk($sformatf("R6 R8 row %0d idle", i), idle_mode, int'(VEC[i][1]));
      chk($sformatf("R6 R9 row %0d pd", i), pdown_mode, int'(VEC[i][0]));
      window(ns, np, nc);
      chk($sformatf("R7 R9 row %0d strobe", i), ns, VEC[i][0] ? 0 : 1);
      chk($sformatf("R7 R9 row %0d per_ce", i), np, VEC[i][0] ? 0 : 6);
      chk($sformatf("R7 R9 row %0d cpu_ce", i), nc, (VEC[i][0] || VEC[i][1]) ? 0 : 6);
    end

    // R9 short reset pulse in power-down
    rst_pin = 1'b1;
    @(negedge clk);
    rst_pin = 1'b0;
    repeat (20) @(negedge clk);
    chk("R9 short pulse keeps pd", pdown_mode, 1);
    chk("R9 short pulse no core reset", core_rst, 0);
    window(ns, np, nc);
    chk("R9 pd enables frozen", np + nc + ns, 0);
    full_reset();
    window(ns, np, nc);
    chk("R9 enables back after exit", np, 6);

    // R6 both bits: power-down wins
    wr(8'h87, 2'b11);
    chk("R6 both bits pd", pdown_mode, 1);
    chk("R6 both bits no idle", idle_mode, 0);
    full_reset();

    // R5 reset clears idle, R6 writes ignored in reset
    wr(8'h87, 2'b01);
    chk("R7 idle entered", idle_mode, 1);
    rst_pin = 1'b1;
    repeat (40) @(negedge clk);
    chk("R5 reset cleared idle", idle_mode, 0);
    wr(8'h87, 2'b01);
    chk("R6 write ignored in reset", idle_mode, 0);
    rst_pin = 1'b0;
    wait_stb(); @(negedge clk);
    chk("R4 release", core_rst, 0);

    // R8 exact wake boundary
    wr(8'h87, 2'b01);
    wait_stb(); @(negedge clk);
    wake_irq = 1'b1;
    repeat (10) @(negedge clk);
    chk("R8 idle before boundary", idle_mode, 1);
    @(negedge clk);
    chk("R8 boundary strobe", mcyc_stb, 1);
    chk("R8 idle still set at strobe", idle_mode, 1);
    @(negedge clk);
    chk("R8 idle cleared at boundary", idle_mode, 0);
    wake_irq = 1'b0;
    window(ns, np, nc);
    chk("R8 cpu_ce resumes", nc, 6);

    // R10 oscillator stall mid cycle
    wait_stb();
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 4) begin
        clk_run = 1'b0;
        #500;
        clk_run = 1'b1;
      end
    end while (!mcyc_stb && n < 40);
    chk("R10 spacing across stall", n, 12);
    window(ns, np, nc);
    chk("R10 per_ce after stall", np, 6);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule